// File: doc/BRIEF.md
# Microcoded Fetch-Decode-Execute Sequencer

This block is the control sequencer of a small microcoded processor. It keeps a microcode address and moves it through three phases. Fetch sits at microaddress 0x000. There the block reads one instruction word from memory at the instruction pointer, holds in place while memory is not ready, and on the ready cycle captures the word into an instruction register and advances the pointer by four. Decode sits at microaddress 0x001 and lasts one cycle. It dispatches on the top four bits of the captured word to one of sixteen entry microaddresses. Execute walks one or more microinstructions from an internal, computed microcode ROM and then returns to fetch.

Each microinstruction carries a control-strobe field, a next-address field and an end-of-instruction bit. A set end bit forces the next microaddress to 0x000. Otherwise the sequencer chains to the next address the word names. The datapath takes the strobes and the 28-bit immediate made from the lower bits of the instruction register. The datapath arithmetic and interrupts live outside this block.

Top module: `mcode_sequencer`

## Requirements
- R1: With `rst_n` low, the next clock edge sets `uaddr` to 0x000 and `ip` to `BOOT_ADDR` (default 0x0000_0100). During that reset `ctrl_strobe` is 0 and `exec_valid` is low.
- R2: `mem_rd` is high exactly while `uaddr` is 0x000, and `mem_addr` equals `ip` at that time. In every other phase `mem_rd` is low.
- R3: While `uaddr` is 0x000 and `mem_ready` is low, the next cycle keeps `uaddr` at 0x000 and leaves `ip` unchanged.
- R4: A clock edge with `uaddr` at 0x000 and `mem_ready` high has three effects in the next cycle: `uaddr` becomes 0x001, `ip` grows by 4, and `imm_operand` shows bits [27:0] of the `mem_rdata` word taken at that edge.
- R5: Decode lasts exactly one cycle. From 0x001 the next microaddress is 0x010 + 4*k, where k is bits [31:28] of the captured word.
- R6: In execute, `exec_valid` is high. `ctrl_strobe` holds {k[3:0] in bits 7:4, step index in bits 3:2, end bit in bit 1, 1 in bit 0}. Opcode k runs (k mod 4)+1 steps, and the step index counts up from 0.
- R7: A microinstruction with its end bit clear chains to its own next-address field, which is the current microaddress plus one.
- R8: A microinstruction with its end bit set is followed directly by microaddress 0x000.
- R9: In fetch and decode, `ctrl_strobe` is 0 and `exec_valid` is low.
- R10: A one-step opcode (k mod 4 = 0) takes exactly one execute cycle with the end bit set, and then returns to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 32 | Read address, driven from the instruction pointer |
| mem_rd | output | 1 | Read request, high during fetch |
| mem_rdata | input | 32 | Instruction word returned by memory |
| mem_ready | input | 1 | Memory has valid data this cycle |
| uaddr | output | 9 | Current microcode address |
| ip | output | 32 | Instruction pointer |
| ctrl_strobe | output | 8 | Control strobes of the executing microinstruction |
| exec_valid | output | 1 | An execute microinstruction is active |
| imm_operand | output | 28 | Lower 28 bits of the instruction register |

## Verification
Every result is due exactly one edge after the stimulus that causes it. A ready fetch edge shows up in the next cycle as microaddress 0x001, the advanced pointer and the new immediate. The dispatch entry follows one cycle after that, and each further execute step comes one cycle after the one before. `mem_rd`, `mem_addr`, `ctrl_strobe` and `exec_valid` are combinational from the current microaddress and can be read in the same cycle. The bench drives inputs and samples outputs on the falling edge, so each sample looks at the state settled after the rising edge before it. It also steps exactly one cycle between expected microaddresses, so a wrong cycle count or a wrong dispatch target shows up as a wrong `uaddr`.

// File: rtl/mseq_pkg.sv
// Package mseq_pkg
// Holds the sequencer phase type and the fixed microaddresses of the
// fetch and decode steps. Assumes the microaddress is at least 2 bits wide.
package mseq_pkg;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

    localparam int unsigned FETCH_UADDR  = 0;
    localparam int unsigned DECODE_UADDR = 1;

endpackage

// File: rtl/mseq_rom.sv
// Module mseq_rom
// Computed microcode store. Opcode k owns a slot of DISP_STRIDE words that
// starts at DISP_BASE + k*DISP_STRIDE and runs (k mod DISP_STRIDE)+1 steps.
// Each used word chains to the next address. Its last word sets the end bit.
// Unused or out-of-range addresses give a word with the end bit set and the
// strobes cleared.
// Assumes CTRL_W >= OPC_W + STEP_W + 2 and DISP_STRIDE is a power of two.
module mseq_rom #(
    parameter int unsigned UADDR_W     = 9,
    parameter int unsigned CTRL_W      = 8,
    parameter int unsigned OPC_W       = 4,
    parameter int unsigned DISP_BASE   = 16,
    parameter int unsigned DISP_STRIDE = 4
) (
    input  logic [UADDR_W-1:0] rd_addr,
    output logic [CTRL_W-1:0]  word_ctrl,
    output logic [UADDR_W-1:0] word_next,
    output logic               word_last
);

    localparam int unsigned STEP_W   = (DISP_STRIDE > 1) ? $clog2(DISP_STRIDE) : 1;
    localparam int unsigned SLOT_END = DISP_BASE + (2 ** OPC_W) * DISP_STRIDE;

    // Work out the microinstruction word at rd_addr from the slot layout.
    always_comb begin
        logic [31:0] a_v;
        logic [31:0] off_v;
        logic [31:0] op_v;
        logic [31:0] step_v;
        logic [31:0] len_v;
        a_v       = 32'(rd_addr);
        off_v     = a_v - DISP_BASE;
        op_v      = off_v / DISP_STRIDE;
        step_v    = off_v % DISP_STRIDE;
        len_v     = (op_v % DISP_STRIDE) + 1;
        word_ctrl = '0;
        word_next = '0;
        word_last = 1'b1;
        if (a_v >= DISP_BASE && a_v < SLOT_END && step_v < len_v) begin
            word_last                     = (step_v == len_v - 1);
            word_next                     = UADDR_W'(a_v + 1);
            word_ctrl[0]                  = 1'b1;
            word_ctrl[1]                  = (step_v == len_v - 1);
            word_ctrl[2 +: STEP_W]        = step_v[STEP_W-1:0];
            word_ctrl[2 + STEP_W +: OPC_W] = op_v[OPC_W-1:0];
        end
    end

endmodule

// File: rtl/mseq_fetch.sv
// Module mseq_fetch
// Instruction pointer and instruction register. When capture is high, the
// returned word is loaded and the pointer advances by IP_STEP.
// Assumes capture is only high in a fetch cycle with memory ready.
module mseq_fetch #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IP_STEP   = 4,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] word_in,
    output logic [ADDR_W-1:0] ip_q,
    output logic [DATA_W-1:0] ir_q
);

    // Hold the pointer and the instruction word, update both on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q <= BOOT_ADDR;
            ir_q <= '0;
        end else if (capture) begin
            ip_q <= ip_q + ADDR_W'(IP_STEP);
            ir_q <= word_in;
        end
    end

endmodule

// File: rtl/mseq_uaddr.sv
// Module mseq_uaddr
// Microaddress register and next-address choice. Fetch stays put until
// memory is ready, then goes to decode. Decode dispatches on the opcode.
// Execute either returns to fetch (end bit) or follows the word's
// next-address field.
// Assumes the dispatch slots fit inside the microaddress range.
module mseq_uaddr
    import mseq_pkg::*;
#(
    parameter int unsigned UADDR_W     = 9,
    parameter int unsigned OPC_W       = 4,
    parameter int unsigned DISP_BASE   = 16,
    parameter int unsigned DISP_STRIDE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase,
    input  logic               mem_ready,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [UADDR_W-1:0] rom_next,
    input  logic               rom_last,
    output logic [UADDR_W-1:0] uaddr_q
);

    logic [UADDR_W-1:0] uaddr_d;
    logic [UADDR_W-1:0] entry;

    // Dispatch target of the current opcode.
    always_comb begin
        entry = UADDR_W'(DISP_BASE + 32'(opcode) * DISP_STRIDE);
    end

    // Select the next microaddress from the phase.
    always_comb begin
        unique case (phase)
            PH_FETCH:  uaddr_d = mem_ready ? UADDR_W'(DECODE_UADDR) : UADDR_W'(FETCH_UADDR);
            PH_DECODE: uaddr_d = entry;
            default:   uaddr_d = rom_last ? UADDR_W'(FETCH_UADDR) : rom_next;
        endcase
    end

    // Microaddress register, cleared to the fetch address on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uaddr_q <= UADDR_W'(FETCH_UADDR);
        end else begin
            uaddr_q <= uaddr_d;
        end
    end

endmodule

// File: rtl/mcode_sequencer.sv
// Module mcode_sequencer
// Top of the fetch-decode-execute control sequencer. It ties the
// microaddress register, the computed microcode store and the
// pointer/instruction registers together and drives the memory read port
// and the control strobes.
// Assumes memory returns read data in the same cycle it raises mem_ready.
module mcode_sequencer
    import mseq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned UADDR_W     = 9,
    parameter int unsigned CTRL_W      = 8,
    parameter int unsigned OPC_W       = 4,
    parameter int unsigned IP_STEP     = 4,
    parameter int unsigned DISP_BASE   = 16,
    parameter int unsigned DISP_STRIDE = 4,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 32'h0000_0100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_rd,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    mem_ready,
    output logic [UADDR_W-1:0]      uaddr,
    output logic [ADDR_W-1:0]       ip,
    output logic [CTRL_W-1:0]       ctrl_strobe,
    output logic                    exec_valid,
    output logic [DATA_W-OPC_W-1:0] imm_operand
);

    localparam int unsigned IMM_W = DATA_W - OPC_W;

    phase_e             phase;
    logic [DATA_W-1:0]  ir;
    logic [CTRL_W-1:0]  rom_ctrl;
    logic [UADDR_W-1:0] rom_next;
    logic               rom_last;
    logic               capture;

    // Classify the current microaddress into a phase.
    always_comb begin
        if (uaddr == UADDR_W'(FETCH_UADDR)) begin
            phase = PH_FETCH;
        end else if (uaddr == UADDR_W'(DECODE_UADDR)) begin
            phase = PH_DECODE;
        end else begin
            phase = PH_EXEC;
        end
    end

    // Memory port, strobe gating and operand outputs.
    always_comb begin
        mem_rd      = (phase == PH_FETCH);
        mem_addr    = ip;
        capture     = (phase == PH_FETCH) && mem_ready;
        exec_valid  = (phase == PH_EXEC);
        ctrl_strobe = exec_valid ? rom_ctrl : '0;
        imm_operand = ir[IMM_W-1:0];
    end

    mseq_uaddr #(
        .UADDR_W    (UADDR_W),
        .OPC_W      (OPC_W),
        .DISP_BASE  (DISP_BASE),
        .DISP_STRIDE(DISP_STRIDE)
    ) u_uaddr (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .mem_ready(mem_ready),
        .opcode   (ir[DATA_W-1 -: OPC_W]),
        .rom_next (rom_next),
        .rom_last (rom_last),
        .uaddr_q  (uaddr)
    );

    mseq_rom #(
        .UADDR_W    (UADDR_W),
        .CTRL_W     (CTRL_W),
        .OPC_W      (OPC_W),
        .DISP_BASE  (DISP_BASE),
        .DISP_STRIDE(DISP_STRIDE)
    ) u_rom (
        .rd_addr  (uaddr),
        .word_ctrl(rom_ctrl),
        .word_next(rom_next),
        .word_last(rom_last)
    );

    mseq_fetch #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IP_STEP  (IP_STEP),
        .BOOT_ADDR(BOOT_ADDR)
    ) u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .word_in(mem_rdata),
        .ip_q   (ip),
        .ir_q   (ir)
    );

endmodule

// File: rtl/mseq_checker.sv
// Module mseq_checker
// Temporal properties of the sequencer, watched only at its ports.
// Bound to every mcode_sequencer instance.
// Assumes the end bit sits at bit 1 of the strobe field.
module mseq_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned UADDR_W = 9,
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned IP_STEP = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_rd,
    input logic               mem_ready,
    input logic [UADDR_W-1:0] uaddr,
    input logic [ADDR_W-1:0]  ip,
    input logic [CTRL_W-1:0]  ctrl_strobe,
    input logic               exec_valid
);

    // R2: fetch reads from the instruction pointer
    p_fetch_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == '0) |-> (mem_rd && mem_addr == ip));

    // R3: stall holds the microaddress and the pointer
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == '0 && !mem_ready) |=> (uaddr == '0 && $stable(ip)));

    // R4: a ready fetch goes to decode and advances the pointer
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == '0 && mem_ready) |=> (uaddr == UADDR_W'(1) && ip == $past(ip) + ADDR_W'(IP_STEP)));

    // R5: decode lasts one cycle and lands in execute
    p_decode_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UADDR_W'(1)) |=> (uaddr != '0 && uaddr != UADDR_W'(1)));

    // R7: a step without the end bit chains to the next address
    p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !ctrl_strobe[1]) |=> (uaddr == $past(uaddr) + UADDR_W'(1)));

    // R8: a step with the end bit returns to fetch
    p_end_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && ctrl_strobe[1]) |=> (uaddr == '0));

    // R9: no strobes outside execute
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_valid) |-> (ctrl_strobe == '0 && (uaddr == '0 || uaddr == UADDR_W'(1))));

endmodule

bind mcode_sequencer mseq_checker #(
    .ADDR_W (ADDR_W),
    .UADDR_W(UADDR_W),
    .CTRL_W (CTRL_W),
    .IP_STEP(IP_STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_ready  (mem_ready),
    .uaddr      (uaddr),
    .ip         (ip),
    .ctrl_strobe(ctrl_strobe),
    .exec_valid (exec_valid)
);

// File: tb/mcode_sequencer_tb.sv
module mcode_sequencer_tb;

    localparam logic [31:0] BOOT = 32'h0000_0100;
    localparam int NVEC = 8;
    // Each vector: {ready delay in cycles [39:32], instruction word [31:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'd0, 32'h0123_4567},
        {8'd2, 32'h1ABC_DEF0},
        {8'd0, 32'h2FFF_FFFF},
        {8'd1, 32'h3000_0001},
        {8'd3, 32'h4555_AAAA},
        {8'd0, 32'h9876_5432},
        {8'd1, 32'hE0F0_F0F0},
        {8'd0, 32'hF123_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [8:0]  uaddr;
    logic [31:0] ip;
    logic [7:0]  ctrl_strobe;
    logic        exec_valid;
    logic [27:0] imm_operand;

    int errors = 0;
    int checks = 0;
    logic [31:0] ip_exp;

    always #4 clk = ~clk;

    mcode_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .uaddr(uaddr), .ip(ip),
        .ctrl_strobe(ctrl_strobe), .exec_valid(exec_valid), .imm_operand(imm_operand)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Fetch-phase checks (R2, R9).
    task automatic chk_fetch();
        chk(uaddr == 9'h000, "R2 uaddr in fetch", 32'(uaddr), 32'h0);
        chk(mem_rd == 1'b1, "R2 mem_rd in fetch", 32'(mem_rd), 32'h1);
        chk(mem_addr == ip_exp, "R2 mem_addr", mem_addr, ip_exp);
        chk(ctrl_strobe == 8'h00 && !exec_valid, "R9 quiet in fetch", 32'(ctrl_strobe), 32'h0);
    endtask

    // Run one instruction through fetch, decode and every execute step.
    task automatic run_instr(input logic [7:0] dly, input logic [31:0] word);
        int k;
        int len;
        k = int'(word[31:28]);
        len = (k % 4) + 1;
        chk_fetch();
        mem_ready = 1'b0;
        for (int d = 0; d < int'(dly); d++) begin
            @(negedge clk);
            chk(uaddr == 9'h000, "R3 stall uaddr", 32'(uaddr), 32'h0);
            chk(ip == ip_exp, "R3 stall ip", ip, ip_exp);
        end
        mem_ready = 1'b1;
        mem_rdata = word;
        @(negedge clk);
        mem_ready = 1'b0;
        mem_rdata = 32'hDEAD_BEEF;
        ip_exp = ip_exp + 32'd4;
        chk(uaddr == 9'h001, "R4 decode uaddr", 32'(uaddr), 32'h1);
        chk(ip == ip_exp, "R4 ip step", ip, ip_exp);
        chk(imm_operand == word[27:0], "R4 immediate", 32'(imm_operand), 32'(word[27:0]));
        chk(mem_rd == 1'b0, "R2 no read in decode", 32'(mem_rd), 32'h0);
        chk(ctrl_strobe == 8'h00 && !exec_valid, "R9 quiet in decode", 32'(ctrl_strobe), 32'h0);
        @(negedge clk);
        chk(uaddr == 9'(16 + 4 * k), "R5 dispatch entry", 32'(uaddr), 32'(16 + 4 * k));
        for (int j = 0; j < len; j++) begin
            logic [7:0] exp_ctrl;
            exp_ctrl = {4'(k), 2'(j), (j == len - 1), 1'b1};
            chk(exec_valid == 1'b1, "R6 exec_valid", 32'(exec_valid), 32'h1);
            chk(ctrl_strobe == exp_ctrl, "R6 strobe field", 32'(ctrl_strobe), 32'(exp_ctrl));
            chk(mem_rd == 1'b0, "R2 no read in execute", 32'(mem_rd), 32'h0);
            @(negedge clk);
            if (j < len - 1) begin
                chk(uaddr == 9'(16 + 4 * k + j + 1), "R7 chain address", 32'(uaddr), 32'(16 + 4 * k + j + 1));
            end
        end
        if (len == 1) begin
            chk(uaddr == 9'h000, "R10 one-step return", 32'(uaddr), 32'h0);
        end else begin
            chk(uaddr == 9'h000, "R8 end bit return", 32'(uaddr), 32'h0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ip_exp = BOOT;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(uaddr == 9'h000, "R1 reset uaddr", 32'(uaddr), 32'h0);
        chk(ip == BOOT, "R1 reset ip", ip, BOOT);
        chk(ctrl_strobe == 8'h00 && !exec_valid, "R1 reset strobes", 32'(ctrl_strobe), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            run_instr(VEC[v][39:32], VEC[v][31:0]);
        end
        // Directed: reset in the middle of execute (R1)
        chk_fetch();
        mem_ready = 1'b1;
        mem_rdata = 32'h7000_0000;
        @(negedge clk);
        mem_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(exec_valid == 1'b1, "R6 exec before reset", 32'(exec_valid), 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(uaddr == 9'h000, "R1 mid-run reset uaddr", 32'(uaddr), 32'h0);
        chk(ip == BOOT, "R1 mid-run reset ip", ip, BOOT);
        chk(ctrl_strobe == 8'h00 && !exec_valid, "R1 mid-run reset strobes", 32'(ctrl_strobe), 32'h0);
        rst_n = 1'b1;
        ip_exp = BOOT;
        @(negedge clk);
        // Directed: a long stall followed by a one-step opcode (R3, R10)
        run_instr(8'd6, 32'h8ABC_0123);
        run_instr(8'd0, 32'hC000_0000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule